// File: doc/BRIEF.md
# Serial Byte Receiver with Break Wake-Up

This block is the receive half of an asynchronous serial port. It rebuilds 8-bit characters from a serial line. Timing comes from an enable pulse that an external baud source supplies at sixteen times the bit rate. Each finished character is stored in a holding register. A pending flag is raised when a character is stored and cleared when software reads the register. A stop-bit error flag comes with each character. A long all-zero break on the line can be seen as a zero character with a stop-bit error.

Software can also arm a wake mode. While it is armed, character assembly is halted. A separate tracker watches for the break: first the line falling, then the line rising. On the rising edge the wake bit clears itself and the pending flag is raised. The tracker runs on the plain clock and does not use the oversampling enable. After this the receiver is back in normal mode and takes the next character, usually a sync byte, with a second flag event.

The character state machine has four states. In `ST_IDLE` it waits for a high-to-low step. In `ST_START` it checks the start bit at mid-bit and returns to `ST_IDLE` if the line reads high. In `ST_DATA` it shifts in the data bits. In `ST_STOP` it samples the stop bit and then returns to `ST_IDLE`. An armed wake forces any state back to `ST_IDLE`. The wake tracker has three states. `WK_OFF` moves to `WK_FALL` when armed. `WK_FALL` moves to `WK_RISE` when the line falls. `WK_RISE` moves back to `WK_OFF` when the line rises, and raises the wake event.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, rx_byte is 00h, and rx_irq, frame_err and wake_en are all 0.
- R2: A character is a low start bit, then 8 data bits sent LSB first, then a stop bit. Each bit lasts 16 os_tick pulses and is sampled near its middle. A start bit is accepted only if the line still reads low halfway through it. The finished byte appears on rx_byte.
- R3: frame_err is 1 when the stop bit was sampled as 0, and 0 when it was sampled as 1. frame_err is updated with every stored byte. A character with a bad stop bit is still stored and still raises rx_irq.
- R4: rx_irq is set when a byte is stored or a wake event occurs. A one-cycle pulse on rd_strobe clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: In normal mode, a break (the line low for at least 13 bit times) gives rx_byte = 00h, frame_err = 1 and rx_irq = 1. While the line stays low after the break, no further character is assembled.
- R6: A pulse on wake_set sets wake_en. While wake_en is 1, no character is assembled, and rx_byte and frame_err keep their values whatever the line does.
- R7: In wake mode, a falling edge followed by a rising edge on the line clears wake_en and sets rx_irq, within 4 clock cycles of the rising edge. This happens even when os_tick is held low.
- R8: Once a wake event has cleared wake_en, the next character is received normally and raises rx_irq again.
- R9: The receiver advances only on os_tick pulses. A tick every third clock gives the same bytes as a tick every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Serial line, asynchronous to clk |
| wake_set | input | 1 | One-cycle pulse that arms wake mode |
| rd_strobe | input | 1 | One-cycle pulse marking a software read of rx_byte |
| rx_byte | output | 8 | Last stored character |
| rx_irq | output | 1 | Pending flag for a character or a wake event |
| frame_err | output | 1 | Stop-bit error of the last stored character |
| wake_en | output | 1 | Wake mode armed |

## Verification
Two events can land on the same clock edge: the clear from a software read and the set from a new character, whether that character is good or bad. To provoke this, the bench first measures how many cycles one character takes to raise rx_irq, starting from the first start-bit cycle. It then sends an identical character at the same tick rate and pulses rd_strobe so that it covers exactly that edge. The set must win: rx_irq must read 1 afterwards and rx_byte must hold the new value. Checks use random characters, with occasional bad stop bits, at two tick rates, plus directed break and wake cases.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        WK_OFF,
        WK_FALL,
        WK_RISE
    } wake_state_t;
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_brk_wake.sv
module uart_brk_wake
    import uart_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic arm,
    output logic wake_en,
    output logic woke
);
    wake_state_t state_q, state_d;
    logic        prev_q;
    logic        woke_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_OFF:  if (arm)            state_d = WK_FALL;
            WK_FALL: if (prev_q && !rx)  state_d = WK_RISE;
            WK_RISE: if (!prev_q && rx)  state_d = WK_OFF;
            default:                     state_d = WK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            woke_q <= 1'b0;
        end else begin
            prev_q <= rx;
            woke_q <= (state_q == WK_RISE) && rx && !prev_q;
        end
    end

    assign wake_en = (state_q != WK_OFF);
    assign woke    = woke_q;

    AST_WOKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        woke_q |-> !wake_en);  // R7
    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && !woke_q) |=> (wake_en || woke_q));  // R6
endmodule

// File: rtl/uart_brk_fsm.sv
module uart_brk_fsm
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    input  logic                 hold,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 stop_bad
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DATA_BITS);
    localparam int MID = OSR / 2 - 1;

    rx_state_t            state_q, state_d;
    logic [CW-1:0]        cnt_q;
    logic [BW-1:0]        bit_q;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 prev_q;
    logic                 done_q;
    logic                 bad_q;
    logic                 cnt_end;
    logic                 cnt_mid;

    assign cnt_end = (cnt_q == CW'(OSR - 1));
    assign cnt_mid = (cnt_q == CW'(MID));

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = ST_IDLE;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:  if (!rx && prev_q) state_d = ST_START;
                ST_START: if (cnt_mid)       state_d = rx ? ST_IDLE : ST_DATA;
                ST_DATA:  if (cnt_end && bit_q == BW'(DATA_BITS - 1)) state_d = ST_STOP;
                ST_STOP:  if (cnt_end)       state_d = ST_IDLE;
                default:                     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            data_q  <= '0;
            prev_q  <= 1'b1;
            done_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) prev_q <= rx;
            if (hold) begin
                cnt_q <= '0;
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE: cnt_q <= '0;
                    ST_START: begin
                        bit_q <= '0;
                        cnt_q <= cnt_mid ? '0 : cnt_q + CW'(1);
                    end
                    ST_DATA: begin
                        if (cnt_end) begin
                            cnt_q   <= '0;
                            shift_q <= {rx, shift_q[DATA_BITS-1:1]};
                            bit_q   <= bit_q + BW'(1);
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (cnt_end) begin
                            cnt_q  <= '0;
                            done_q <= 1'b1;
                            data_q <= shift_q;
                            bad_q  <= !rx;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign done     = done_q;
    assign data     = data_q;
    assign stop_bad = bad_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == ST_IDLE));  // R6
    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |=> (done_q || ($stable(data_q) && $stable(bad_q))));  // R6
    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(state_q));  // R9
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rx_in,
    input  logic                 wake_set,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_irq,
    output logic                 frame_err,
    output logic                 wake_en
);
    logic rx_s;
    logic woke;
    logic byte_done;
    logic irq_q;

    uart_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    uart_brk_wake u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx      (rx_s),
        .arm     (wake_set),
        .wake_en (wake_en),
        .woke    (woke)
    );

    uart_brk_fsm #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rx       (rx_s),
        .hold     (wake_en),
        .done     (byte_done),
        .data     (rx_byte),
        .stop_bad (frame_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  irq_q <= 1'b0;
        else if (byte_done || woke)  irq_q <= 1'b1;
        else if (rd_strobe)          irq_q <= 1'b0;
    end

    assign rx_irq = irq_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done || woke) |=> rx_irq);  // R4
    AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !byte_done && !woke) |=> !rx_irq);  // R4
    AST_NO_BYTE_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_done && woke));  // R6
endmodule

// File: tb/uart_brk_rx_test.sv
module uart_brk_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       wake_set = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_irq;
    logic       frame_err;
    logic       wake_en;

    int  checks = 0;
    int  fails = 0;
    int  div = 1;
    bit  tick_on = 1'b1;
    int  tcnt = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    uart_brk_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_in     (rx_in),
        .wake_set  (wake_set),
        .rd_strobe (rd_strobe),
        .rx_byte   (rx_byte),
        .rx_irq    (rx_irq),
        .frame_err (frame_err),
        .wake_en   (wake_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        os_tick <= tick_on && (tcnt == 0);
        tcnt    <= (tcnt >= div - 1) ? 0 : tcnt + 1;
    end

    function automatic logic exp_ferr(input logic stop);
        return !stop;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int bits);
        rx_in = v;
        repeat (16 * div * bits) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        hold_line(1'b0, 1);
        for (int i = 0; i < 8; i++) hold_line(b[i], 1);
        hold_line(stop, 1);
        hold_line(1'b1, 1);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic       s;
        logic [7:0] keep;
        int         t0;
        int         lat;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 byte", rx_byte, 8'h00);
        check("R1 irq", rx_irq, 0);
        check("R1 ferr", frame_err, 0);
        check("R1 wake", wake_en, 0);
        rst_n = 1'b1;
        hold_line(1'b1, 2);

        // R2 R3 R4: random characters at one tick per clock
        for (int n = 0; n < 20; n++) begin
            b = 8'($urandom);
            s = ($urandom % 6) != 0;
            send_frame(b, s);
            check("R2 byte", rx_byte, b);
            check("R3 ferr", frame_err, exp_ferr(s));
            check("R4 irq set", rx_irq, 1);
            do_read();
            check("R4 irq cleared", rx_irq, 0);
        end

        // R3 directed bad stop bit
        send_frame(8'h3C, 1'b0);
        check("R3 bad stop stored", rx_byte, 8'h3C);
        check("R3 bad stop flagged", frame_err, 1);
        do_read();

        // R4 collision: measure latency, then read on the set edge
        @(negedge clk);
        t0 = cyc;
        fork
            send_frame(8'h96, 1'b1);
            begin
                while (!rx_irq) @(negedge clk);
                lat = cyc - t0;
            end
        join
        do_read();
        check("R4 cleared before collision", rx_irq, 0);
        @(negedge clk);
        t0 = cyc;
        fork
            send_frame(8'h69, 1'b1);
            begin
                while (cyc != t0 + lat - 1) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        check("R4 set wins over read", rx_irq, 1);
        check("R4 collision byte", rx_byte, 8'h69);
        do_read();

        // R9: tick every third clock
        div = 3;
        hold_line(1'b1, 1);
        for (int n = 0; n < 6; n++) begin
            b = 8'($urandom);
            send_frame(b, 1'b1);
            check("R9 slow tick byte", rx_byte, b);
            check("R9 slow tick ferr", frame_err, 0);
            do_read();
        end
        div = 1;
        hold_line(1'b1, 1);

        // R5: break in normal mode
        hold_line(1'b0, 14);
        check("R5 break byte", rx_byte, 8'h00);
        check("R5 break ferr", frame_err, 1);
        check("R5 break irq", rx_irq, 1);
        do_read();
        hold_line(1'b0, 4);
        check("R5 no extra byte while low", rx_irq, 0);
        hold_line(1'b1, 2);
        check("R5 no extra byte after", rx_irq, 0);

        // R6: wake mode suspends assembly (ticks running)
        send_frame(8'h5A, 1'b1);
        do_read();
        keep = rx_byte;
        @(negedge clk);
        wake_set = 1'b1;
        @(negedge clk);
        wake_set = 1'b0;
        check("R6 wake set", wake_en, 1);
        hold_line(1'b0, 1);
        hold_line(1'b0, 4);
        check("R6 no irq in wake", rx_irq, 0);
        check("R6 still armed", wake_en, 1);
        check("R6 byte kept", rx_byte, keep);
        check("R6 ferr kept", frame_err, 0);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 wake cleared", wake_en, 0);
        check("R7 wake irq", rx_irq, 1);
        check("R6 byte kept after wake", rx_byte, keep);
        do_read();
        check("R7 read clears wake irq", rx_irq, 0);

        // R7 with os_tick held low, then R8
        tick_on = 1'b0;
        hold_line(1'b1, 1);
        @(negedge clk);
        wake_set = 1'b1;
        @(negedge clk);
        wake_set = 1'b0;
        check("R6 wake set again", wake_en, 1);
        hold_line(1'b0, 13);
        check("R7 armed during break", wake_en, 1);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 cleared without ticks", wake_en, 0);
        check("R7 irq without ticks", rx_irq, 1);
        do_read();
        tick_on = 1'b1;
        hold_line(1'b1, 1);
        send_frame(8'hA5, 1'b1);
        check("R8 byte after wake", rx_byte, 8'hA5);
        check("R8 ferr after wake", frame_err, 0);
        check("R8 second irq", rx_irq, 1);
        do_read();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule